// File: doc/BRIEF.md
# Saturating Line-Code Error Counter

This block accumulates code-violation events from a line receiver into a 16-bit count that stops at its maximum rather than wrapping. A line-code select input picks which of two violation strobes is counted: the HDB3 violation strobe (also used when CMI with HDB3 precoding is in effect) or the AMI bipolar-violation strobe. An alarm-simulation input replaces real events with a synthetic increment on every fourth received-bit strobe.

Software sees the count through a byte-wide read port as a low byte and a high byte, both taken from a snapshot buffer. Two readout schemes exist. In host-freeze mode the buffer follows the live count until the host sets a freeze bit. That rising edge takes a final snapshot and clears the live count. Reading the high byte releases the freeze. In per-second mode each one-second tick copies the live count into the buffer and clears it, and the buffer then holds until the next tick.

Top module: `lcv_counter`

## Requirements
- R1: After reset the live count, the snapshot buffer, the freeze bit and the read data are all zero.
- R2: With `line_code` = 0 (HDB3), each cycle with `hdb3_viol` high adds one to the count and `ami_viol` has no effect.
- R3: With `line_code` = 1 (AMI), each cycle with `ami_viol` high adds one to the count and `hdb3_viol` has no effect.
- R4: The count never wraps. At 0xFFFF further increments leave it at 0xFFFF.
- R5: While `alarm_sim` is high the count rises by one on every fourth `bit_tick` strobe, counted from when `alarm_sim` went high, and both violation strobes are ignored.
- R6: With `ro_mode` = 0 and the freeze bit clear, the buffer takes the live count at every clock edge, so it shows the count as of the previous edge.
- R7: With `ro_mode` = 0, writing 1 to the freeze bit while it is clear copies the live count into the buffer and clears the live count on that edge. The buffer then holds while the bit stays set.
- R8: A high-byte read strobe clears the freeze bit, and the buffer resumes tracking. A freeze write in the same cycle takes priority.
- R9: Writing 1 to the freeze bit while it is already set does not clear the live count again.
- R10: With `ro_mode` = 1, a `sec_tick` copies the live count into the buffer and clears the live count. The buffer keeps that value until the next tick, and freeze writes do not clear the count.
- R11: An increment in the same cycle as a clear counts toward the new interval, so the live count becomes 1.
- R12: A read strobe returns the selected buffer byte on `rd_data` one cycle later, with `rd_vld` high. `rd_hi` selects the high byte (bits 15:8) and wins over `rd_lo`, which selects bits 7:0. A low-byte read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_code | input | 1 | 0 selects HDB3 violations, 1 selects AMI bipolar violations |
| hdb3_viol | input | 1 | HDB3 violation strobe |
| ami_viol | input | 1 | AMI bipolar-violation strobe |
| alarm_sim | input | 1 | Alarm-simulation enable |
| bit_tick | input | 1 | One pulse per received bit period |
| ro_mode | input | 1 | 0 selects host-freeze readout, 1 selects per-second latching |
| sec_tick | input | 1 | One-second strobe |
| frz_wr | input | 1 | Write strobe for the freeze bit |
| frz_wdata | input | 1 | Value written to the freeze bit |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| rd_data | output | 8 | Registered read data |
| rd_vld | output | 1 | Read data valid, one cycle after a strobe |
| frz_flag | output | 1 | Current freeze bit |

## Verification
The counting path is driven with violation strobes on both inputs under each line-code setting, which separates a correct source select from a swapped or merged one. It is also driven with alarm simulation and a mix of bit strobes and stray violations, which shows whether the divide-by-four and the masking are right. A continuous strobe past 65535 events exposes wrapping. Strobes placed on the exact cycle of a freeze or a one-second tick show whether the coincident event is lost, counted in the old interval or counted in the new one. A repeated freeze write, low-byte reads during a freeze and a combined read of both bytes separate edge detection from level detection, and show that only the high-byte read releases the freeze.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
   typedef enum logic {
      LC_HDB3 = 1'b0,
      LC_AMI  = 1'b1
   } line_code_e;

   typedef enum logic {
      RO_FREEZE = 1'b0,
      RO_SECOND = 1'b1
   } readout_e;
endpackage

// File: rtl/lcv_event_sel.sv
module lcv_event_sel
   import lcv_pkg::*;
#(
   parameter int ALARM_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  line_code_e line_code,
   input  logic       hdb3_viol,
   input  logic       ami_viol,
   input  logic       alarm_sim,
   input  logic       bit_tick,
   output logic       inc
);
   if (ALARM_DIV < 1) begin : g_bad_div
      $error("ALARM_DIV must be at least 1");
   end

   logic alarm_pulse;

   if (ALARM_DIV == 1) begin : g_nodiv
      assign alarm_pulse = bit_tick;
   end else begin : g_div
      localparam int DW = $clog2(ALARM_DIV);
      localparam logic [DW-1:0] LAST = DW'(ALARM_DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                div_q <= '0;
         else if (!alarm_sim)       div_q <= '0;
         else if (bit_tick)         div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
      end

      assign alarm_pulse = bit_tick && (div_q == LAST);
   end

   always_comb begin
      if (alarm_sim)               inc = alarm_pulse;
      else if (line_code == LC_AMI) inc = ami_viol;
      else                         inc = hdb3_viol;
   end

   assert_alarm_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_sim && !bit_tick) |-> !inc);
   assert_hdb3_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_sim && line_code == LC_HDB3 && !hdb3_viol) |-> !inc);
   assert_ami_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_sim && line_code == LC_AMI && !ami_viol) |-> !inc);
endmodule

// File: rtl/lcv_sat_counter.sv
module lcv_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   if (W < 2) begin : g_bad_w
      $error("W must be at least 2");
   end

   localparam logic [W-1:0] MAX = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (clr)                  cnt <= W'(inc);
      else if (inc && cnt != MAX)    cnt <= cnt + 1'b1;
   end

   assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == MAX && !clr) |=> cnt == MAX);
   assert_clear_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == W'($past(inc)));
   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/lcv_snapshot.sv
module lcv_snapshot
   import lcv_pkg::*;
#(
   parameter int W      = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  readout_e          ro_mode,
   input  logic              sec_tick,
   input  logic              frz_wr,
   input  logic              frz_wdata,
   input  logic              rd_lo,
   input  logic              rd_hi,
   input  logic [W-1:0]      cnt,
   output logic              clr,
   output logic              frz,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_vld
);
   if (W != 2 * BYTE_W) begin : g_bad_split
      $error("W must be exactly two bytes wide");
   end

   logic [W-1:0] buf_q;
   logic         frz_rise;
   logic         buf_load;

   assign frz_rise = frz_wr && frz_wdata && !frz;
   assign clr      = (ro_mode == RO_SECOND) ? sec_tick
                                            : frz_rise;
   assign buf_load = (ro_mode == RO_SECOND) ? sec_tick
                                            : !frz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        frz <= 1'b0;
      else if (frz_wr)   frz <= frz_wdata;
      else if (rd_hi)    frz <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        buf_q <= '0;
      else if (buf_load) buf_q <= cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_vld  <= 1'b0;
      end else begin
         rd_vld <= rd_lo || rd_hi;
         if (rd_hi)      rd_data <= buf_q[W-1 -: BYTE_W];
         else if (rd_lo) rd_data <= buf_q[BYTE_W-1:0];
      end
   end

   assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ro_mode == RO_FREEZE && frz) |=> $stable(buf_q));
   assert_hi_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi && !frz_wr) |=> !frz);
   assert_sec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ro_mode == RO_SECOND && !sec_tick) |=> $stable(buf_q));
   assert_lo_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && !rd_hi && !frz_wr) |=> frz == $past(frz));
endmodule

// File: rtl/lcv_counter.sv
module lcv_counter
   import lcv_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int BYTE_W    = 8,
   parameter int ALARM_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_code,
   input  logic              hdb3_viol,
   input  logic              ami_viol,
   input  logic              alarm_sim,
   input  logic              bit_tick,
   input  logic              ro_mode,
   input  logic              sec_tick,
   input  logic              frz_wr,
   input  logic              frz_wdata,
   input  logic              rd_lo,
   input  logic              rd_hi,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_vld,
   output logic              frz_flag
);
   logic             inc;
   logic             clr;
   logic [CNT_W-1:0] cnt;

   lcv_event_sel #(.ALARM_DIV(ALARM_DIV)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_code (line_code_e'(line_code)),
      .hdb3_viol (hdb3_viol),
      .ami_viol  (ami_viol),
      .alarm_sim (alarm_sim),
      .bit_tick  (bit_tick),
      .inc       (inc)
   );

   lcv_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc),
      .clr   (clr),
      .cnt   (cnt)
   );

   lcv_snapshot #(.W(CNT_W), .BYTE_W(BYTE_W)) u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .ro_mode   (readout_e'(ro_mode)),
      .sec_tick  (sec_tick),
      .frz_wr    (frz_wr),
      .frz_wdata (frz_wdata),
      .rd_lo     (rd_lo),
      .rd_hi     (rd_hi),
      .cnt       (cnt),
      .clr       (clr),
      .frz       (frz_flag),
      .rd_data   (rd_data),
      .rd_vld    (rd_vld)
   );

   assert_reset_zero_R1: assert property (@(posedge clk)
      !rst_n |=> (!frz_flag && rd_data == '0 && !rd_vld));
endmodule

// File: tb/tb_lcv_counter.sv
`timescale 1ns/100ps
module tb_lcv_counter;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_code = 0, hdb3_viol = 0, ami_viol = 0, alarm_sim = 0, bit_tick = 0;
   logic ro_mode = 0, sec_tick = 0, frz_wr = 0, frz_wdata = 0, rd_lo = 0, rd_hi = 0;
   logic [7:0] rd_data;
   logic       rd_vld, frz_flag;

   always #2.5 clk = ~clk;

   lcv_counter dut (
      .clk(clk), .rst_n(rst_n), .line_code(line_code), .hdb3_viol(hdb3_viol),
      .ami_viol(ami_viol), .alarm_sim(alarm_sim), .bit_tick(bit_tick),
      .ro_mode(ro_mode), .sec_tick(sec_tick), .frz_wr(frz_wr),
      .frz_wdata(frz_wdata), .rd_lo(rd_lo), .rd_hi(rd_hi),
      .rd_data(rd_data), .rd_vld(rd_vld), .frz_flag(frz_flag)
   );

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t sb_q[$];
   int    n_chk = 0;
   int    n_bad = 0;
   string cur_tag = "R12";
   bit    done = 0;

   // requirement-level model of the count, buffer and freeze bit
   logic [15:0] m_cnt = 0, m_buf = 0;
   logic        m_frz = 0;
   int          m_div = 0;

   task automatic clear_strobes();
      hdb3_viol = 0; ami_viol = 0; bit_tick = 0; sec_tick = 0;
      frz_wr = 0; frz_wdata = 0; rd_lo = 0; rd_hi = 0;
   endtask

   task automatic cyc();
      logic        inc, rise, clr;
      logic [15:0] nbuf;
      item_t       it;
      if (alarm_sim) inc = bit_tick && (m_div == 3);
      else           inc = line_code ? ami_viol : hdb3_viol;
      if (rd_hi || rd_lo) begin
         it.exp = rd_hi ? m_buf[15:8] : m_buf[7:0];
         it.tag = cur_tag;
         sb_q.push_back(it);
      end
      rise = frz_wr && frz_wdata && !m_frz;
      clr  = ro_mode ? sec_tick : rise;
      nbuf = m_buf;
      if (ro_mode ? sec_tick : !m_frz) nbuf = m_cnt;
      if (clr)                              m_cnt = {15'd0, inc};
      else if (inc && m_cnt != 16'hFFFF)    m_cnt = m_cnt + 16'd1;
      m_buf = nbuf;
      if (frz_wr)     m_frz = frz_wdata;
      else if (rd_hi) m_frz = 0;
      if (!alarm_sim)    m_div = 0;
      else if (bit_tick) m_div = (m_div + 1) % 4;
      @(posedge clk);
      #1;
      clear_strobes();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic rd(bit hi, string tag);
      cur_tag = tag;
      rd_hi = hi; rd_lo = !hi;
      cyc();
   endtask

   task automatic rd_both(string tag);
      rd(0, tag);
      rd(1, tag);
   endtask

   task automatic chk_bit(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: frz_flag act=%0b exp=%0b", tag, act, exp);
      end
   endtask

   task automatic frz_write(bit v);
      frz_wr = 1; frz_wdata = v;
   endtask

   // monitor: pops the scoreboard whenever read data is presented
   always @(negedge clk) begin
      if (rst_n && rd_vld && !done) begin
         n_chk++;
         if (sb_q.size() == 0) begin
            n_bad++;
            $display("FAIL R12: unexpected read data act=%02h exp=none", rd_data);
         end else begin
            item_t it;
            it = sb_q.pop_front();
            if (rd_data !== it.exp) begin
               n_bad++;
               $display("FAIL %s: rd_data act=%02h exp=%02h", it.tag, rd_data, it.exp);
            end
         end
      end
   end

   initial begin
      #1500000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      clear_strobes();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state
      chk_bit("R1", frz_flag, 0);
      rd_both("R1");

      // R2: HDB3 counts hdb3_viol only
      line_code = 0;
      for (int i = 0; i < 5; i++) begin hdb3_viol = 1; ami_viol = (i < 3); cyc(); end
      idle(2);
      rd_both("R2");

      // R3: AMI counts ami_viol only
      line_code = 1;
      for (int i = 0; i < 7; i++) begin ami_viol = 1; hdb3_viol = (i < 4); cyc(); end
      idle(1);
      rd_both("R3");

      // R6: buffer tracks with one-edge lag
      for (int i = 0; i < 4; i++) begin ami_viol = 1; cyc(); rd(0, "R6"); end
      ami_viol = 1; rd_lo = 1; cur_tag = "R6"; cyc();

      // R7 / R11: freeze coincident with an event
      ami_viol = 1; frz_write(1); cyc();
      chk_bit("R7", frz_flag, 1);
      for (int i = 0; i < 3; i++) begin ami_viol = 1; cyc(); end
      rd(0, "R7");
      chk_bit("R12", frz_flag, 1);
      // R9: second write of 1 must not clear again
      frz_write(1); ami_viol = 1; cyc();
      for (int i = 0; i < 2; i++) begin ami_viol = 1; cyc(); end
      rd(0, "R9");
      // R12: combined strobe returns high byte and releases
      cur_tag = "R12"; rd_lo = 1; rd_hi = 1; cyc();
      chk_bit("R8", frz_flag, 0);
      idle(1);
      rd_both("R9");
      // R8: read with simultaneous freeze write keeps the freeze
      frz_write(1); cyc();
      rd_hi = 1; frz_write(1); cur_tag = "R8"; cyc();
      chk_bit("R8", frz_flag, 1);
      rd(1, "R8");
      chk_bit("R8", frz_flag, 0);
      idle(1);
      rd_both("R8");

      // R10 / R11: per-second latching
      ro_mode = 1; line_code = 0;
      for (int i = 0; i < 4; i++) begin hdb3_viol = 1; cyc(); end
      sec_tick = 1; hdb3_viol = 1; cyc();
      for (int i = 0; i < 2; i++) begin hdb3_viol = 1; cyc(); end
      frz_write(1); hdb3_viol = 1; cyc();
      rd_both("R10");
      sec_tick = 1; cyc();
      rd_both("R11");
      frz_write(0); cyc();
      sec_tick = 1; cyc();
      rd_both("R10");

      // R5: alarm simulation
      ro_mode = 0; alarm_sim = 1;
      for (int i = 0; i < 14; i++) begin bit_tick = (i % 3 != 2); hdb3_viol = 1; ami_viol = 1; cyc(); end
      alarm_sim = 0;
      idle(1);
      rd_both("R5");

      // R4: saturation
      ro_mode = 0; line_code = 0;
      for (int i = 0; i < 65545; i++) begin hdb3_viol = 1; cyc(); end
      idle(1);
      rd_both("R4");
      n_chk++;
      if (m_buf !== 16'hFFFF) begin
         n_bad++;
         $display("FAIL R4: model buf act=%04h exp=ffff", m_buf);
      end
      idle(3);
      done = 1;
      n_chk++;
      if (sb_q.size() != 0) begin
         n_bad++;
         $display("FAIL R12: pending reads act=%0d exp=0", sb_q.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule